// File: doc/BRIEF.md
# Debounced Edge Interrupt Bank

This block turns a bank of general-purpose input pins into one interrupt line. Each pin passes through a two-flop synchronizer, then an optional debounce filter paced by an external millisecond tick, then an edge detector that can watch for rising edges, falling edges, both, or nothing. Detected edges latch into a per-pin pending register that software clears by writing ones. A per-pin mask register gates which pending bits may raise the bank interrupt.

The register decode lives in the surrounding GPIO controller. That controller hands this block one shared write-data bus and three decoded write strobes: clear pending, set mask, clear mask. Each pin's interrupt settings arrive as a six-bit slice of that pin's control word, namely control-word bits 8 down to 3. Level-sensitive triggering is not offered.

Top module: `edge_irq_bank`

## Requirements
- R1: While reset is high, and on the first cycle after it, the pending register reads all zeros, the mask register reads all ones and the interrupt is low.
- R2: A trigger code of 1 in configuration bits [1:0] (control-word bits [4:3]) latches the pin's pending bit when the filtered input goes from low to high.
- R3: A trigger code of 2 latches the pending bit when the filtered input goes from high to low.
- R4: A trigger code of 3 latches on either transition. A trigger code of 0 never latches, and no code latches on a steady level.
- R5: With debounce off (configuration bit 5, control-word bit 8, clear), an input change on a rising-edge pin shows in the pending register after exactly the fourth rising clock edge that follows it, and not after the third.
- R6: With debounce on, configuration bits [4:2] (control-word bits [7:5]) hold n. A new level is accepted only after it has differed from the accepted level on 2^n tick pulses without returning. A shorter excursion leaves no pending bit.
- R7: A clear-pending write clears each pending bit whose write-data bit is 1 and leaves the rest. If an edge on a pin coincides with a clear of its bit, the bit stays set.
- R8: A set-mask write sets each mask bit whose write-data bit is 1. A clear-mask write clears them. When both strobes hit the same bit in one cycle, the bit ends up set.
- R9: The interrupt is high exactly while some pending bit has its mask bit clear. Masked pins still latch pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond, paces debounce |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_cfg | input | NPINS*6 | Per-pin slice of control-word bits [8:3]: {debounce enable, n[2:0], trigger[1:0]} |
| wdata | input | NPINS | Shared register write data |
| stat_clr_we | input | 1 | Clear-pending write strobe |
| mask_set_we | input | 1 | Set-mask write strobe |
| mask_clr_we | input | 1 | Clear-mask write strobe |
| int_status | output | NPINS | Pending edge register |
| int_mask | output | NPINS | Mask register |
| bank_irq | output | 1 | Bank interrupt |

## Verification
The bench builds the block with eight pins instead of thirty-two and pulses the tick every fourth clock. At these settings each trigger code, a pin without debounce, and debounce exponents of 0, 2 and 7 each get a pin of their own. The full 128 ms window then completes in about five hundred cycles, so the longest debounce case fits inside one run next to the random traffic.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DB_EXP_W = 3;
    localparam int MAX_EXP  = (1 << DB_EXP_W) - 1;
    localparam int CNT_W    = MAX_EXP + 1;
    localparam int CFG_W    = 6;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    typedef struct packed {
        logic                db_en;
        logic [DB_EXP_W-1:0] db_exp;
        trig_e               trig;
    } pin_cfg_t;

    // Last count value of a 2^e tick window.
    function automatic logic [CNT_W-1:0] window_last(input logic [DB_EXP_W-1:0] e);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        return (one << e) - one;
    endfunction

endpackage

// File: rtl/in_sync.sv
module in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pin_filter.sv
module pin_filter
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     sin,
    input  pin_cfg_t cfg,
    output logic     evt
);
    logic             level;
    logic             level_d;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= 1'b0;
            level_d <= 1'b0;
            cnt     <= '0;
        end else begin
            level_d <= level;
            if (!cfg.db_en) begin
                level <= sin;
                cnt   <= '0;
            end else if (sin == level) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt >= window_last(cfg.db_exp)) begin
                    level <= sin;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (cfg.trig)
            TRIG_RISE: evt = level & ~level_d;
            TRIG_FALL: evt = ~level & level_d;
            TRIG_BOTH: evt = level ^ level_d;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] wdata,
    input  logic             stat_clr_we,
    input  logic             mask_set_we,
    input  logic             mask_clr_we,
    output logic [NPINS-1:0] status,
    output logic [NPINS-1:0] mask,
    output logic             irq
);
    logic [NPINS-1:0] clr_bits, set_bits, unmask_bits;

    assign clr_bits    = stat_clr_we ? wdata : '0;
    assign set_bits    = mask_set_we ? wdata : '0;
    assign unmask_bits = mask_clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~clr_bits) | evt;
            mask   <= (mask & ~unmask_bits) | set_bits;
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ms_tick,
    input  logic [NPINS-1:0]       pin_in,
    input  logic [NPINS*CFG_W-1:0] pin_cfg,
    input  logic [NPINS-1:0]       wdata,
    input  logic                   stat_clr_we,
    input  logic                   mask_set_we,
    input  logic                   mask_clr_we,
    output logic [NPINS-1:0]       int_status,
    output logic [NPINS-1:0]       int_mask,
    output logic                   bank_irq
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] edge_evt;

    in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_filter u_filt (
            .clk  (clk),
            .rst  (rst),
            .tick (ms_tick),
            .sin  (pin_sync[p]),
            .cfg  (pin_cfg_t'(pin_cfg[p*CFG_W +: CFG_W])),
            .evt  (edge_evt[p])
        );
    end

    irq_regs #(.NPINS(NPINS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .evt         (edge_evt),
        .wdata       (wdata),
        .stat_clr_we (stat_clr_we),
        .mask_set_we (mask_set_we),
        .mask_clr_we (mask_clr_we),
        .status      (int_status),
        .mask        (int_mask),
        .irq         (bank_irq)
    );
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] wdata,
    input logic             stat_clr_we,
    input logic             mask_set_we,
    input logic             mask_clr_we,
    input logic [NPINS-1:0] edge_evt,
    input logic [NPINS-1:0] int_status,
    input logic [NPINS-1:0] int_mask
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int_status == '0 && int_mask == '1));

    // R7
    clear_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(int_status) & ~($past(stat_clr_we) ? $past(wdata) : '0)
                  & ~int_status) == '0));

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(edge_evt) & ~int_status) == '0));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        mask_set_we |=> (($past(wdata) & ~int_mask) == '0));

    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_clr_we && !mask_set_we) |=> (($past(wdata) & int_mask) == '0));
endmodule

bind edge_irq_bank edge_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wdata       (wdata),
    .stat_clr_we (stat_clr_we),
    .mask_set_we (mask_set_we),
    .mask_clr_we (mask_clr_we),
    .edge_evt    (edge_evt),
    .int_status  (int_status),
    .int_mask    (int_mask)
);

// File: tb/sim_edge_irq_bank.sv
`timescale 1ns/1ps
module sim_edge_irq_bank;
    localparam int N  = 8;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ms_tick = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic [N*CW-1:0] pin_cfg;
    logic [N-1:0]  wdata = '0;
    logic          stat_clr_we = 1'b0;
    logic          mask_set_we = 1'b0;
    logic          mask_clr_we = 1'b0;
    logic [N-1:0]  int_status, int_mask;
    logic          bank_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit compare_on = 0;

    always #4 clk = ~clk;

    edge_irq_bank #(.NPINS(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pin_in(pin_in), .pin_cfg(pin_cfg),
        .wdata(wdata), .stat_clr_we(stat_clr_we), .mask_set_we(mask_set_we),
        .mask_clr_we(mask_clr_we), .int_status(int_status), .int_mask(int_mask),
        .bank_irq(bank_irq)
    );

    // per-pin settings: {db_en, n, trig}
    int cfg_trig [N] = '{1, 2, 3, 0, 1, 1, 3, 1};
    int cfg_den  [N] = '{0, 0, 0, 0, 1, 1, 1, 0};
    int cfg_n    [N] = '{0, 0, 0, 0, 0, 2, 7, 0};

    always_comb begin
        for (int i = 0; i < N; i++)
            pin_cfg[i*CW +: CW] = {cfg_den[i][0], cfg_n[i][2:0], cfg_trig[i][1:0]};
    end

    // tick every fourth cycle
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        ms_tick <= (tick_div == 0);
    end

    // behavioural reference model
    int s1 [N], s2 [N], acc [N], prev [N], cnt [N];
    logic [N-1:0] m_stat, m_mask;

    always @(posedge clk) begin
        logic [N-1:0] ev;
        int win;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                s1[i] = 0; s2[i] = 0; acc[i] = 0; prev[i] = 0; cnt[i] = 0;
            end
            m_stat = '0;
            m_mask = '1;
        end else begin
            for (int i = 0; i < N; i++) begin
                case (cfg_trig[i])
                    1: ev[i] = (acc[i] == 1 && prev[i] == 0);
                    2: ev[i] = (acc[i] == 0 && prev[i] == 1);
                    3: ev[i] = (acc[i] != prev[i]);
                    default: ev[i] = 1'b0;
                endcase
            end
            for (int i = 0; i < N; i++) begin
                prev[i] = acc[i];
                win = (1 << cfg_n[i]);
                if (cfg_den[i] == 0) begin
                    acc[i] = s2[i]; cnt[i] = 0;
                end else if (s2[i] == acc[i]) begin
                    cnt[i] = 0;
                end else if (ms_tick) begin
                    cnt[i] = cnt[i] + 1;
                    if (cnt[i] >= win) begin
                        acc[i] = s2[i]; cnt[i] = 0;
                    end
                end
                s2[i] = s1[i];
                s1[i] = pin_in[i];
            end
            m_stat = (m_stat & ~(stat_clr_we ? wdata : '0)) | ev;
            m_mask = (m_mask & ~(mask_clr_we ? wdata : '0)) | (mask_set_we ? wdata : '0);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && !rst) begin
            check("R7 model status", int_status, m_stat);
            check("R8 model mask", int_mask, m_mask);
            check("R9 model irq", bank_irq, |(m_stat & ~m_mask));
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input int kind, input logic [N-1:0] d);
        @(negedge clk);
        wdata = d;
        stat_clr_we = (kind == 0);
        mask_set_we = (kind == 1);
        mask_clr_we = (kind == 2);
        @(negedge clk);
        stat_clr_we = 0; mask_set_we = 0; mask_clr_we = 0; wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        cyc(3);
        check("R1 status in reset", int_status, 0);
        check("R1 mask in reset", int_mask, 8'hFF);
        check("R1 irq in reset", bank_irq, 0);
        rst = 0;
        cyc(1);
        check("R1 status after reset", int_status, 0);
        check("R1 mask after reset", int_mask, 8'hFF);
        compare_on = 1;

        wr(2, 8'hFF);
        check("R8 mask cleared", int_mask, 8'h00);

        // rising on pins 0..3
        pin_in[3:0] = 4'hF;
        cyc(6);
        check("R2 rise pin0 latched", int_status[0], 1);
        check("R3 fall pin1 ignores rise", int_status[1], 0);
        check("R4 both pin2 on rise", int_status[2], 1);
        check("R4 none pin3", int_status[3], 0);
        check("R9 irq with pending", bank_irq, 1);
        cyc(6);
        check("R4 steady level no relatch", int_status, 8'h05);
        wr(0, 8'h05);
        check("R7 W1C cleared", int_status, 0);
        check("R9 irq low when empty", bank_irq, 0);

        pin_in[3:0] = 4'h0;
        cyc(6);
        check("R2 rise pin0 ignores fall", int_status[0], 0);
        check("R3 fall pin1 latched", int_status[1], 1);
        check("R4 both pin2 on fall", int_status[2], 1);
        check("R4 none pin3 on fall", int_status[3], 0);
        wr(0, 8'hFF);

        // R5 latency
        @(negedge clk);
        pin_in[7] = 1;
        cyc(3);
        check("R5 not after third edge", int_status[7], 0);
        cyc(1);
        check("R5 set after fourth edge", int_status[7], 1);
        wr(0, 8'h80);
        pin_in[7] = 0;
        cyc(6);

        // R6 debounce n=2: short pulse filtered, long accepted
        pin_in[5] = 1;
        cyc(6);
        pin_in[5] = 0;
        cyc(40);
        check("R6 short pulse filtered", int_status[5], 0);
        pin_in[5] = 1;
        cyc(30);
        check("R6 long level accepted", int_status[5], 1);
        // n=0 pin4
        pin_in[4] = 1;
        cyc(12);
        check("R6 n0 accepted", int_status[4], 1);
        // n=7 pin6: 128 ticks
        pin_in[6] = 1;
        cyc(400);
        check("R6 n7 still filtering", int_status[6], 0);
        cyc(200);
        check("R6 n7 accepted", int_status[6], 1);
        wr(0, 8'hFF);

        // R7 collision: clear lands on the event edge
        @(negedge clk);
        pin_in[0] = 1;
        cyc(3);
        wdata = 8'h01; stat_clr_we = 1;
        @(negedge clk);
        stat_clr_we = 0; wdata = '0;
        check("R7 event beats clear", int_status[0], 1);

        // R8/R9 masking
        wr(1, 8'hFF);
        check("R9 masked irq low", bank_irq, 0);
        check("R9 pending kept under mask", int_status[0], 1);
        pin_in[7] = 1;
        cyc(6);
        check("R9 masked pin latches", int_status[7], 1);
        check("R9 irq still low", bank_irq, 0);
        wr(2, 8'h80);
        check("R9 unmask raises irq", bank_irq, 1);
        @(negedge clk);
        wdata = 8'h80; mask_set_we = 1; mask_clr_we = 1;
        @(negedge clk);
        mask_set_we = 0; mask_clr_we = 0; wdata = '0;
        check("R8 set wins over clear", int_mask[7], 1);
        check("R8 irq after remask", bank_irq, 0);

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (($urandom % 5) == 0) pin_in = N'($urandom);
            wdata = N'($urandom);
            stat_clr_we = (($urandom % 6) == 0);
            mask_set_we = (($urandom % 9) == 0);
            mask_clr_we = (($urandom % 7) == 0);
        end
        @(negedge clk);
        stat_clr_we = 0; mask_set_we = 0; mask_clr_we = 0;
        cyc(4);
        finish_run();
    end
endmodule